// File: doc/BRIEF.md
# Rolling Row Scan Sequencer

This block paces the rolling-shutter readout of a pixel matrix of 640 rows. Each row is held for a fixed number of fast readout clocks. The default is 160 clocks, which at a 160 MHz readout clock gives a 1 MHz row rate and a 640 µs frame. Every row is visited once per frame. Along the way the block produces:

- a binary and a one-hot row select;
- a row-start pulse and an end-of-row discriminator strobe;
- an in-pixel timing enable every 10 readout clocks;
- a frame-start marker;
- a 16-bit frame counter.

Several chips that share a clock compare their markers and frame counts to confirm they are aligned. A control register drives a resync input, which returns every chip to the start of frame 0 on the same edge. An enable input pauses the scan without losing its position.

Every output is registered. Each one reports the scan cycle that was consumed at the previous rising edge while enable was high.

Top module: `rowscan_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `row_idx`, `cycle_idx`, `frame_cnt` and all four pulses are zero, and `row_onehot` has only bit 0 set.
- R2: Each enabled clock consumes one scan cycle. `cycle_idx` reports 0..159 in turn. `row_idx` advances after cycle 159 and wraps from 639 to 0. Both report the cycle consumed at the preceding edge.
- R3: `row_onehot` always has exactly one bit set, and it is bit number `row_idx`.
- R4: `row_start` is high for one clock when the reported cycle is 0. `disc_strobe` is high for one clock when the reported cycle is 159.
- R5: `pix_tick` is high when the reported cycle is a multiple of 10, which gives 16 ticks per row.
- R6: `frame_start` is high only when the reported position is row 0, cycle 0.
- R7: `frame_cnt` increases by one on the edge that consumes row 639, cycle 159. It wraps to 0 on overflow of its FRAME_W bits.
- R8: With `enable` low and `resync` low, `row_idx`, `cycle_idx`, `row_onehot` and `frame_cnt` hold their values and all pulses are low. The next enabled clock resumes at the held position.
- R9: `resync` high on an edge zeroes the position and the frame counter, and drives all pulses low. It overrides `enable`, and the next enabled clock reports row 0, cycle 0 with `frame_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast readout clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Advance the scan by one cycle per clock |
| resync | input | 1 | Synchronous return to row 0, cycle 0, frame 0 |
| row_idx | output | 10 | Binary index of the reported row |
| row_onehot | output | 640 | One-hot row select |
| cycle_idx | output | 8 | Reported cycle within the row |
| row_start | output | 1 | First cycle of a row |
| frame_start | output | 1 | First cycle of row 0 |
| disc_strobe | output | 1 | Last cycle of a row, discriminator latch |
| pix_tick | output | 1 | In-pixel timing enable |
| frame_cnt | output | 16 | Completed-frame counter |

## Verification
The bench runs one complete frame and continues past the wrap from row 639 to row 0. A design that miscounted the row length or the wrap point would drift from the model and raise `frame_start` at the wrong place. A second, small instance is run through eight frames with a 3-bit frame counter, so that a counter that saturates or skips on overflow is exposed. Pauses are interleaved one clock at a time, which catches any pulse that stretches while frozen and any step lost on resume. A resync is applied in mid-row with enable high and again with enable low, which catches a resync that loses priority or leaves the frame counter intact.

// File: rtl/rowscan_pkg.sv
package rowscan_pkg;
  parameter int unsigned DEF_ROWS    = 640;
  parameter int unsigned DEF_CYCLES  = 160;
  parameter int unsigned DEF_TICK    = 10;
  parameter int unsigned DEF_FRAME_W = 16;

  typedef struct packed {
    logic row_start;
    logic frame_start;
    logic disc_strobe;
    logic pix_tick;
  } rs_marks_t;
endpackage

// File: rtl/rs_mod_ctr.sv
// Modulo-MOD counter with a registered value and a combinational wrap carry.
module rs_mod_ctr #(
  parameter int unsigned MOD = 10,
  parameter int unsigned W   = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] val,
  output logic         wrap
);
  logic at_last;

  assign at_last = (val == W'(MOD - 1));
  assign wrap    = inc && at_last;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      val <= '0;
    end else if (inc) begin
      val <= at_last ? '0 : val + W'(1);
    end
  end
endmodule

// File: rtl/rs_row_decode.sv
// Registered binary-to-one-hot row select.
module rs_row_decode #(
  parameter int unsigned ROWS  = 640,
  parameter int unsigned ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [ROW_W-1:0] row_in,
  output logic [ROWS-1:0]  onehot
);
  logic [ROWS-1:0] dec;

  for (genvar g = 0; g < ROWS; g++) begin : g_dec
    assign dec[g] = (row_in == ROW_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      onehot <= ROWS'(1);
    end else if (load) begin
      onehot <= dec;
    end
  end
endmodule

// File: rtl/rowscan_seq.sv
module rowscan_seq
  import rowscan_pkg::*;
#(
  parameter int unsigned NUM_ROWS   = DEF_ROWS,
  parameter int unsigned ROW_CYCLES = DEF_CYCLES,
  parameter int unsigned TICK_DIV   = DEF_TICK,
  parameter int unsigned FRAME_W    = DEF_FRAME_W,
  localparam int unsigned ROW_W  = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
  localparam int unsigned CYC_W  = (ROW_CYCLES > 1) ? $clog2(ROW_CYCLES) : 1,
  localparam int unsigned TICK_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  logic                resync,
  output logic [ROW_W-1:0]    row_idx,
  output logic [NUM_ROWS-1:0] row_onehot,
  output logic [CYC_W-1:0]    cycle_idx,
  output logic                row_start,
  output logic                frame_start,
  output logic                disc_strobe,
  output logic                pix_tick,
  output logic [FRAME_W-1:0]  frame_cnt
);
  // Scan position: the cycle that the next enabled edge consumes.
  logic [ROW_W-1:0]  row_q;
  logic [CYC_W-1:0]  cyc_q;
  logic [TICK_W-1:0] tick_q;
  logic              cyc_wrap;
  logic              row_wrap;
  rs_marks_t         marks_q;

  rs_mod_ctr #(.MOD(ROW_CYCLES), .W(CYC_W)) u_cyc_ctr (
    .clk (clk),
    .rst (rst),
    .clr (resync),
    .inc (enable),
    .val (cyc_q),
    .wrap(cyc_wrap)
  );

  rs_mod_ctr #(.MOD(NUM_ROWS), .W(ROW_W)) u_row_ctr (
    .clk (clk),
    .rst (rst),
    .clr (resync),
    .inc (cyc_wrap),
    .val (row_q),
    .wrap(row_wrap)
  );

  rs_row_decode #(.ROWS(NUM_ROWS), .ROW_W(ROW_W)) u_row_dec (
    .clk   (clk),
    .rst   (rst),
    .load  (enable || resync),
    .row_in(resync ? '0 : row_q),
    .onehot(row_onehot)
  );

  // Report registers, the pixel-tick divider and the frame counter.
  always_ff @(posedge clk) begin
    if (rst || resync) begin
      row_idx   <= '0;
      cycle_idx <= '0;
      marks_q   <= '0;
      tick_q    <= '0;
      frame_cnt <= '0;
    end else if (enable) begin
      row_idx             <= row_q;
      cycle_idx           <= cyc_q;
      marks_q.row_start   <= (cyc_q == '0);
      marks_q.frame_start <= (cyc_q == '0) && (row_q == '0);
      marks_q.disc_strobe <= cyc_wrap;
      marks_q.pix_tick    <= (tick_q == '0);
      tick_q              <= (cyc_wrap || tick_q == TICK_W'(TICK_DIV - 1)) ? '0 : tick_q + TICK_W'(1);
      if (row_wrap) begin
        frame_cnt <= frame_cnt + FRAME_W'(1);
      end
    end else begin
      marks_q <= '0;
    end
  end

  assign row_start   = marks_q.row_start;
  assign frame_start = marks_q.frame_start;
  assign disc_strobe = marks_q.disc_strobe;
  assign pix_tick    = marks_q.pix_tick;
endmodule

// File: rtl/rowscan_seq_chk.sv
module rowscan_seq_chk #(
  parameter int unsigned NUM_ROWS   = 640,
  parameter int unsigned ROW_CYCLES = 160,
  parameter int unsigned TICK_DIV   = 10,
  parameter int unsigned FRAME_W    = 16,
  localparam int unsigned ROW_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
  localparam int unsigned CYC_W = (ROW_CYCLES > 1) ? $clog2(ROW_CYCLES) : 1
) (
  input logic                clk,
  input logic                rst,
  input logic                enable,
  input logic                resync,
  input logic [ROW_W-1:0]    row_idx,
  input logic [NUM_ROWS-1:0] row_onehot,
  input logic [CYC_W-1:0]    cycle_idx,
  input logic                row_start,
  input logic                frame_start,
  input logic                disc_strobe,
  input logic                pix_tick,
  input logic [FRAME_W-1:0]  frame_cnt
);
  a_r2_position_range: assert property (@(posedge clk) disable iff (rst)
    (32'(row_idx) < NUM_ROWS) && (32'(cycle_idx) < ROW_CYCLES));

  a_r3_onehot_matches: assert property (@(posedge clk) disable iff (rst)
    ($countones(row_onehot) == 1) && row_onehot[row_idx]);

  a_r4_row_start_at_zero: assert property (@(posedge clk) disable iff (rst)
    row_start |-> (cycle_idx == '0));

  a_r4_strobe_at_end: assert property (@(posedge clk) disable iff (rst)
    disc_strobe |-> (32'(cycle_idx) == ROW_CYCLES - 1));

  a_r5_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    pix_tick |-> ((32'(cycle_idx) % TICK_DIV) == 0));

  a_r6_frame_start_origin: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (row_start && row_idx == '0 && cycle_idx == '0));

  a_r7_frame_steps_by_one: assert property (@(posedge clk) disable iff (rst)
    (frame_cnt != $past(frame_cnt)) |-> ((frame_cnt == $past(frame_cnt) + FRAME_W'(1)) || $past(resync)));

  a_r8_freeze_holds: assert property (@(posedge clk) disable iff (rst)
    (!enable && !resync) |=> ($stable(row_idx) && $stable(cycle_idx) && $stable(frame_cnt)
                              && !row_start && !frame_start && !disc_strobe && !pix_tick));

  a_r9_resync_clears: assert property (@(posedge clk) disable iff (rst)
    resync |=> (row_idx == '0 && cycle_idx == '0 && frame_cnt == '0 && !row_start && !frame_start));
endmodule

bind rowscan_seq rowscan_seq_chk #(
  .NUM_ROWS  (NUM_ROWS),
  .ROW_CYCLES(ROW_CYCLES),
  .TICK_DIV  (TICK_DIV),
  .FRAME_W   (FRAME_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .enable     (enable),
  .resync     (resync),
  .row_idx    (row_idx),
  .row_onehot (row_onehot),
  .cycle_idx  (cycle_idx),
  .row_start  (row_start),
  .frame_start(frame_start),
  .disc_strobe(disc_strobe),
  .pix_tick   (pix_tick),
  .frame_cnt  (frame_cnt)
);

// File: tb/rowscan_seq_bench.sv
`timescale 1ns/1ps
module rowscan_seq_bench;
  localparam int ROWS = 640;
  localparam int CYC  = 160;
  localparam int TICK = 10;

  logic clk = 1'b0;
  logic rst, enable, resync, en_s;

  logic [9:0]      row_idx;
  logic [ROWS-1:0] row_onehot;
  logic [7:0]      cycle_idx;
  logic            row_start, frame_start, disc_strobe, pix_tick;
  logic [15:0]     frame_cnt;

  logic [1:0] s_row;
  logic [3:0] s_oh;
  logic [4:0] s_cyc;
  logic       s_rs, s_fs, s_ds, s_pt;
  logic [2:0] s_frame;

  always #4 clk = ~clk;

  rowscan_seq u_rowscan_seq (
    .clk(clk), .rst(rst), .enable(enable), .resync(resync),
    .row_idx(row_idx), .row_onehot(row_onehot), .cycle_idx(cycle_idx),
    .row_start(row_start), .frame_start(frame_start), .disc_strobe(disc_strobe),
    .pix_tick(pix_tick), .frame_cnt(frame_cnt)
  );

  // Small geometry with a 3-bit frame counter for the wrap case.
  rowscan_seq #(.NUM_ROWS(4), .ROW_CYCLES(20), .TICK_DIV(10), .FRAME_W(3)) u_small (
    .clk(clk), .rst(rst), .enable(en_s), .resync(1'b0),
    .row_idx(s_row), .row_onehot(s_oh), .cycle_idx(s_cyc),
    .row_start(s_rs), .frame_start(s_fs), .disc_strobe(s_ds),
    .pix_tick(s_pt), .frame_cnt(s_frame)
  );

  typedef struct {
    int    row;
    int    cyc;
    bit    rs;
    bit    fs;
    bit    ds;
    bit    pt;
    int    frame;
    string tag;
  } exp_t;

  exp_t q[$];
  int n_checks = 0;
  int n_fail   = 0;
  int m_row = 0, m_cyc = 0, m_frame = 0, rep_row = 0, rep_cyc = 0;

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: apply one clock of stimulus and predict the reported result.
  task automatic step(input bit en, input bit rs);
    exp_t e;
    @(negedge clk);
    enable = en;
    resync = rs;
    if (rs) begin
      e = '{0, 0, 0, 0, 0, 0, 0, "R9"};
      m_row = 0; m_cyc = 0; m_frame = 0; rep_row = 0; rep_cyc = 0;
    end else if (en) begin
      e.row = m_row;
      e.cyc = m_cyc;
      e.rs  = (m_cyc == 0);
      e.fs  = (m_cyc == 0) && (m_row == 0);
      e.ds  = (m_cyc == CYC - 1);
      e.pt  = (m_cyc % TICK == 0);
      e.tag = "";
      rep_row = m_row;
      rep_cyc = m_cyc;
      m_cyc++;
      if (m_cyc == CYC) begin
        m_cyc = 0;
        m_row++;
        if (m_row == ROWS) begin
          m_row = 0;
          m_frame = (m_frame + 1) % 65536;
        end
      end
      e.frame = m_frame;
    end else begin
      e = '{rep_row, rep_cyc, 0, 0, 0, 0, m_frame, "R8"};
    end
    q.push_back(e);
  endtask

  // Monitor: compare after each rising edge, away from both edges.
  always @(posedge clk) begin
    exp_t e;
    logic [ROWS-1:0] exp_oh;
    #2;
    if (q.size() > 0) begin
      e = q.pop_front();
      exp_oh = '0;
      exp_oh[e.row] = 1'b1;
      check((e.tag != "") ? {e.tag, " row"}   : "R2 row",         row_idx,     e.row);
      check((e.tag != "") ? {e.tag, " cycle"} : "R2 cycle",       cycle_idx,   e.cyc);
      check((e.tag != "") ? {e.tag, " 1hot"}  : "R3 onehot",      (row_onehot == exp_oh) ? 1 : 0, 1);
      check((e.tag != "") ? {e.tag, " rs"}    : "R4 row_start",   row_start,   e.rs);
      check((e.tag != "") ? {e.tag, " ds"}    : "R4 disc_strobe", disc_strobe, e.ds);
      check((e.tag != "") ? {e.tag, " pt"}    : "R5 pix_tick",    pix_tick,    e.pt);
      check((e.tag != "") ? {e.tag, " fs"}    : "R6 frame_start", frame_start, e.fs);
      check((e.tag != "") ? {e.tag, " frame"} : "R7 frame_cnt",   frame_cnt,   e.frame);
    end
  end

  initial begin
    #(8 * 190000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; enable = 1'b0; resync = 1'b0; en_s = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values
    check("R1 row",   row_idx, 0);
    check("R1 cycle", cycle_idx, 0);
    check("R1 frame", frame_cnt, 0);
    check("R1 pulses", {row_start, frame_start, disc_strobe, pix_tick}, 0);
    check("R1 onehot", row_onehot, 1);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1 post-release hold", {row_idx, cycle_idx, frame_cnt}, 0);

    // R7 wrap on the small instance (80 cycles per frame), main frozen (R8).
    @(negedge clk);
    en_s = 1'b1;
    repeat (560) step(1'b0, 1'b0);
    check("R7 small frame before wrap", s_frame, 7);
    repeat (80) step(1'b0, 1'b0);
    check("R7 small frame wrap", s_frame, 0);
    en_s = 1'b0;

    // R2..R6 normal scan, then interleaved pauses (R8).
    repeat (200) step(1'b1, 1'b0);
    for (int i = 0; i < 30; i++) begin
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
    end
    // R9: resync in mid-row with enable high.
    step(1'b1, 1'b1);
    // Full frame and beyond: row wrap, frame increment, second frame_start.
    repeat (ROWS * CYC + 500) step(1'b1, 1'b0);
    // R9: resync with enable low, then resume.
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    repeat (20) step(1'b1, 1'b0);

    @(posedge clk);
    #3;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule